// File: doc/BRIEF.md
# Victim Line Buffer for a Direct-Mapped Cache

This block is a small, fully associative side store placed between a direct-mapped cache and the next level of memory. It keeps whole lines that the main cache has thrown out, so that conflict misses can often be served locally. When the main cache misses, it sends a lookup to this block. The lookup carries the block address being sought. It also carries the line that currently occupies the main-cache slot, which is the line about to be displaced.

Every entry compares its stored block address against the lookup at the same time. If one entry matches, its line is returned to the main cache for installation. In the same clock edge, the displaced line takes the matching entry's place, so the two lines trade homes and memory is never touched. If nothing matches, the displaced line is written into the buffer. The buffer fills an empty entry first. When all entries are full, it overwrites the entry that was least recently inserted or hit. The lookup address is then forwarded to the lower level, and the line that comes back is passed on as the response.

The lookup, the response, the lower-level request and the line return each use a valid/ready handshake. The displaced-line fields belong to the lookup beat and are sampled together with it. Only one lookup is in flight at a time. `lkp_ready` is high only when the block is idle. While `rsp_ready` or `mem_req_ready` is low, the response and the request hold steady. The line return is taken only while `mem_ret_ready` is high.

Top module: `victim_cache_ctrl`

## Requirements
- R1: After reset no entry is valid. `lkp_ready` is 1, `rsp_valid` and `mem_req_valid` are 0, and the first lookup misses.
- R2: `lkp_ready` is 1 only when no response or request is pending. While `rsp_valid` is 1 and `rsp_ready` is 0, `rsp_valid`, `rsp_hit` and `rsp_data` stay unchanged.
- R3: On a lookup whose block address matches a valid entry, `rsp_valid` is 1 in the cycle after acceptance, with `rsp_hit`=1 and `rsp_data` equal to the stored line. `mem_req_valid` stays 0.
- R4: On such a hit with `ev_valid`=1, the matched entry is overwritten by `ev_addr`/`ev_data`. A later lookup of `ev_addr` hits with `ev_data`, and the hit address no longer hits.
- R5: On a lookup that matches no entry, `mem_req_valid` is 1 in the cycle after acceptance with `mem_req_addr` equal to the lookup address. Both hold until `mem_req_ready` is 1.
- R6: A line return accepted with `mem_ret_valid` and `mem_ret_ready` both 1 yields `rsp_valid`=1 in the next cycle, with `rsp_hit`=0 and `rsp_data` equal to the returned line.
- R7: On a miss with `ev_valid`=1, the displaced line is stored. With `ev_valid`=0 nothing is stored, and a later lookup of that `ev_addr` misses.
- R8: Matching uses every bit of the block address. An address that differs from a stored one in the top bit or in the bottom bit does not hit.
- R9: An insertion uses an invalid entry if one exists. Otherwise it overwrites the entry least recently inserted or hit.
- R10: A hit with `ev_valid`=0 frees the matched entry, so a repeat lookup of that address misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lkp_valid | input | 1 | Lookup offered |
| lkp_ready | output | 1 | Lookup can be accepted (idle) |
| lkp_addr | input | ADDR_W | Block address sought |
| ev_valid | input | 1 | The main-cache slot holds a line to displace |
| ev_addr | input | ADDR_W | Block address of the displaced line |
| ev_data | input | LINE_W | Contents of the displaced line |
| rsp_valid | output | 1 | Response line available |
| rsp_ready | input | 1 | Main cache takes the response |
| rsp_hit | output | 1 | 1 = served from the buffer, 0 = served by memory |
| rsp_data | output | LINE_W | Line to install in the main cache |
| mem_req_valid | output | 1 | Lower-level read request |
| mem_req_ready | input | 1 | Lower level accepts the request |
| mem_req_addr | output | ADDR_W | Block address requested |
| mem_ret_valid | input | 1 | Returned line available |
| mem_ret_ready | output | 1 | Block waits for the returned line |
| mem_ret_data | input | LINE_W | Returned line |

## Verification
A lookup is accepted on a rising edge. One cycle later, its outcome is already visible: either a hit response or a lower-level request. A returned line becomes a response one cycle after the edge that accepts it. The bench drives every input on the falling edge and samples on the next falling edge after the accepting rising edge, so it observes exactly the first cycle in which each result is due. It then holds `rsp_ready` or `mem_req_ready` low for one more cycle and samples again to confirm that the output is held.

// File: rtl/vc_pkg.sv
package vc_pkg;
  typedef enum logic [1:0] {
    VC_IDLE  = 2'd0,
    VC_MREQ  = 2'd1,
    VC_MWAIT = 2'd2,
    VC_RSP   = 2'd3
  } vc_state_e;
endpackage

// File: rtl/vc_store.sv
// Entry storage: one valid bit, block address and line per entry.
module vc_store #(
  parameter int ENTRIES = 4,
  parameter int ADDR_W  = 27,
  parameter int LINE_W  = 128,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             wr_en,
  input  logic [IDX_W-1:0]                 wr_idx,
  input  logic [ADDR_W-1:0]                wr_addr,
  input  logic [LINE_W-1:0]                wr_data,
  input  logic                             inv_en,
  input  logic [IDX_W-1:0]                 inv_idx,
  output logic [ENTRIES-1:0][ADDR_W-1:0]   tags,
  output logic [ENTRIES-1:0][LINE_W-1:0]   lines,
  output logic [ENTRIES-1:0]               valid
);
  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    logic              v_q;
    logic [ADDR_W-1:0] t_q;
    logic [LINE_W-1:0] d_q;
    logic              sel_wr;
    logic              sel_inv;

    assign sel_wr  = wr_en  && (wr_idx  == IDX_W'(g));
    assign sel_inv = inv_en && (inv_idx == IDX_W'(g));

    always_ff @(posedge clk) begin
      if (!rst_n)       v_q <= 1'b0;
      else if (sel_wr)  v_q <= 1'b1;
      else if (sel_inv) v_q <= 1'b0;
    end

    always_ff @(posedge clk) begin
      if (sel_wr) begin
        t_q <= wr_addr;
        d_q <= wr_data;
      end
    end

    assign valid[g] = v_q;
    assign tags[g]  = t_q;
    assign lines[g] = d_q;
  end
endmodule

// File: rtl/vc_match.sv
// Parallel comparators, one per entry, plus a one-hot line select.
module vc_match #(
  parameter int ENTRIES = 4,
  parameter int ADDR_W  = 27,
  parameter int LINE_W  = 128,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic [ADDR_W-1:0]                probe_addr,
  input  logic [ENTRIES-1:0][ADDR_W-1:0]   tags,
  input  logic [ENTRIES-1:0][LINE_W-1:0]   lines,
  input  logic [ENTRIES-1:0]               valid,
  output logic [ENTRIES-1:0]               hit_vec,
  output logic                             hit_any,
  output logic [IDX_W-1:0]                 hit_idx,
  output logic [LINE_W-1:0]                hit_line
);
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign hit_vec[g] = valid[g] && (tags[g] == probe_addr);
  end

  assign hit_any = |hit_vec;

  always_comb begin
    hit_idx  = '0;
    hit_line = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (hit_vec[i]) hit_idx = IDX_W'(i);
      hit_line = hit_line | (lines[i] & {LINE_W{hit_vec[i]}});
    end
  end
endmodule

// File: rtl/vc_lru.sv
// Age ranking: 0 = most recent, ENTRIES-1 = oldest. Ages stay a permutation.
module vc_lru #(
  parameter int ENTRIES = 4,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               touch_en,
  input  logic [IDX_W-1:0]   touch_idx,
  input  logic [ENTRIES-1:0] valid,
  output logic [IDX_W-1:0]   repl_idx
);
  localparam int AGE_W = IDX_W;

  logic [ENTRIES-1:0][AGE_W-1:0] age;
  logic [AGE_W-1:0]              touch_age;
  logic                          free_found;

  assign touch_age = age[touch_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) age[i] <= AGE_W'(i);
    end else if (touch_en) begin
      for (int j = 0; j < ENTRIES; j++) begin
        if (IDX_W'(j) == touch_idx)   age[j] <= '0;
        else if (age[j] < touch_age)  age[j] <= age[j] + AGE_W'(1);
      end
    end
  end

  always_comb begin
    repl_idx   = '0;
    free_found = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (!valid[i] && !free_found) begin
        repl_idx   = IDX_W'(i);
        free_found = 1'b1;
      end
    end
    if (!free_found) begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (age[i] == AGE_W'(ENTRIES - 1)) repl_idx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/victim_cache_ctrl.sv
module victim_cache_ctrl #(
  parameter int ENTRIES = 4,
  parameter int ADDR_W  = 27,
  parameter int LINE_W  = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lkp_valid,
  output logic              lkp_ready,
  input  logic [ADDR_W-1:0] lkp_addr,
  input  logic              ev_valid,
  input  logic [ADDR_W-1:0] ev_addr,
  input  logic [LINE_W-1:0] ev_data,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_hit,
  output logic [LINE_W-1:0] rsp_data,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_ret_valid,
  output logic              mem_ret_ready,
  input  logic [LINE_W-1:0] mem_ret_data
);
  import vc_pkg::*;

  localparam int IDX_W = $clog2(ENTRIES);

  vc_state_e state_q;
  logic [ADDR_W-1:0] req_addr_q;
  logic [LINE_W-1:0] rsp_data_q;
  logic              rsp_hit_q;

  logic [ENTRIES-1:0][ADDR_W-1:0] tags;
  logic [ENTRIES-1:0][LINE_W-1:0] lines;
  logic [ENTRIES-1:0]             valid;
  logic [ENTRIES-1:0]             hit_vec;
  logic                           hit_any;
  logic [IDX_W-1:0]               hit_idx;
  logic [LINE_W-1:0]              hit_line;
  logic [IDX_W-1:0]               repl_idx;

  logic             fire;
  logic             wr_en;
  logic [IDX_W-1:0] wr_idx;
  logic             inv_en;

  assign lkp_ready     = (state_q == VC_IDLE);
  assign fire          = lkp_valid && lkp_ready;
  assign wr_en         = fire && ev_valid;
  assign wr_idx        = hit_any ? hit_idx : repl_idx;
  assign inv_en        = fire && hit_any && !ev_valid;

  assign mem_req_valid = (state_q == VC_MREQ);
  assign mem_req_addr  = req_addr_q;
  assign mem_ret_ready = (state_q == VC_MWAIT);
  assign rsp_valid     = (state_q == VC_RSP);
  assign rsp_hit       = rsp_hit_q;
  assign rsp_data      = rsp_data_q;

  vc_store #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .LINE_W(LINE_W)) store_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_addr (ev_addr),
    .wr_data (ev_data),
    .inv_en  (inv_en),
    .inv_idx (hit_idx),
    .tags    (tags),
    .lines   (lines),
    .valid   (valid)
  );

  vc_match #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .LINE_W(LINE_W)) match_i (
    .probe_addr (lkp_addr),
    .tags       (tags),
    .lines      (lines),
    .valid      (valid),
    .hit_vec    (hit_vec),
    .hit_any    (hit_any),
    .hit_idx    (hit_idx),
    .hit_line   (hit_line)
  );

  vc_lru #(.ENTRIES(ENTRIES)) lru_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .touch_en  (wr_en),
    .touch_idx (wr_idx),
    .valid     (valid),
    .repl_idx  (repl_idx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= VC_IDLE;
      req_addr_q <= '0;
      rsp_data_q <= '0;
      rsp_hit_q  <= 1'b0;
    end else begin
      unique case (state_q)
        VC_IDLE: if (fire) begin
          if (hit_any) begin
            rsp_data_q <= hit_line;
            rsp_hit_q  <= 1'b1;
            state_q    <= VC_RSP;
          end else begin
            req_addr_q <= lkp_addr;
            state_q    <= VC_MREQ;
          end
        end
        VC_MREQ:  if (mem_req_ready) state_q <= VC_MWAIT;
        VC_MWAIT: if (mem_ret_valid) begin
          rsp_data_q <= mem_ret_data;
          rsp_hit_q  <= 1'b0;
          state_q    <= VC_RSP;
        end
        VC_RSP:   if (rsp_ready) state_q <= VC_IDLE;
        default:  state_q <= VC_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/vc_checker.sv
module vc_checker #(
  parameter int ENTRIES = 4,
  parameter int ADDR_W  = 27,
  parameter int LINE_W  = 128
) (
  input logic              clk,
  input logic              rst_n,
  input logic              lkp_valid,
  input logic              lkp_ready,
  input logic [ADDR_W-1:0] lkp_addr,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic              rsp_hit,
  input logic [LINE_W-1:0] rsp_data,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic              mem_ret_valid,
  input logic              mem_ret_ready,
  input logic [LINE_W-1:0] mem_ret_data,
  input logic [ENTRIES-1:0] hit_vec,
  input logic              hit_any
);
  AST_IDLE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    lkp_ready |-> (!rsp_valid && !mem_req_valid && !mem_ret_ready)); // R2

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data) && $stable(rsp_hit))); // R2

  AST_HIT_RESP: assert property (@(posedge clk) disable iff (!rst_n)
    (lkp_valid && lkp_ready && hit_any) |=> (rsp_valid && rsp_hit && !mem_req_valid)); // R3

  AST_MISS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (lkp_valid && lkp_ready && !hit_any) |=> (mem_req_valid && mem_req_addr == $past(lkp_addr))); // R5

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr))); // R5

  AST_RET_RESP: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_ret_valid && mem_ret_ready) |=> (rsp_valid && !rsp_hit && rsp_data == $past(mem_ret_data))); // R6

  AST_SINGLE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec)); // R8
endmodule

bind victim_cache_ctrl vc_checker #(
  .ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .LINE_W(LINE_W)
) chk_i (.*);

// File: tb/victim_cache_ctrl_tb_top.sv
module victim_cache_ctrl_tb_top;
  localparam int AW = 27;
  localparam int LW = 128;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          lkp_valid = 1'b0;
  logic          lkp_ready;
  logic [AW-1:0] lkp_addr = '0;
  logic          ev_valid = 1'b0;
  logic [AW-1:0] ev_addr = '0;
  logic [LW-1:0] ev_data = '0;
  logic          rsp_valid;
  logic          rsp_ready = 1'b0;
  logic          rsp_hit;
  logic [LW-1:0] rsp_data;
  logic          mem_req_valid;
  logic          mem_req_ready = 1'b0;
  logic [AW-1:0] mem_req_addr;
  logic          mem_ret_valid = 1'b0;
  logic          mem_ret_ready;
  logic [LW-1:0] mem_ret_data = '0;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  victim_cache_ctrl #(.ENTRIES(4), .ADDR_W(AW), .LINE_W(LW)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .lkp_valid(lkp_valid), .lkp_ready(lkp_ready), .lkp_addr(lkp_addr),
    .ev_valid(ev_valid), .ev_addr(ev_addr), .ev_data(ev_data),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_hit(rsp_hit), .rsp_data(rsp_data),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_ret_valid(mem_ret_valid), .mem_ret_ready(mem_ret_ready), .mem_ret_data(mem_ret_data)
  );

  function automatic logic [LW-1:0] mem_line(input logic [AW-1:0] a);
    return {5'd3, a, 5'd9, a, 5'd17, a, 5'd21, a} ^ 128'h5A5A_0F0F_3C3C_9696_A5A5_F0F0_C3C3_6969;
  endfunction

  function automatic logic [LW-1:0] ev_line(input logic [AW-1:0] a);
    return ~mem_line(a);
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [LW-1:0] act, input logic [LW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // One full lookup transaction; hit/miss outcome and data are checked.
  task automatic lookup(input logic [AW-1:0] addr, input bit evv, input logic [AW-1:0] eaddr,
                        input bit exp_hit, input logic [LW-1:0] exp_data, input string req);
    @(negedge clk);
    chk("R2", "lkp_ready idle", LW'(lkp_ready), LW'(1));
    lkp_valid = 1'b1; lkp_addr = addr;
    ev_valid = evv; ev_addr = eaddr; ev_data = ev_line(eaddr);
    @(negedge clk);
    lkp_valid = 1'b0; ev_valid = 1'b0;
    chk("R2", "lkp_ready busy", LW'(lkp_ready), LW'(0));
    if (exp_hit) begin
      chk(req, "hit rsp_valid", LW'(rsp_valid), LW'(1));
      chk(req, "hit rsp_hit", LW'(rsp_hit), LW'(1));
      chk("R3", "no mem_req on hit", LW'(mem_req_valid), LW'(0));
      chk(req, "hit rsp_data", rsp_data, exp_data);
    end else begin
      chk(req, "miss mem_req_valid", LW'(mem_req_valid), LW'(1));
      chk("R5", "miss mem_req_addr", LW'(mem_req_addr), LW'(addr));
      chk("R5", "no rsp yet", LW'(rsp_valid), LW'(0));
      @(negedge clk);
      chk("R5", "req held", LW'(mem_req_valid), LW'(1));
      chk("R5", "req addr held", LW'(mem_req_addr), LW'(addr));
      mem_req_ready = 1'b1;
      @(negedge clk);
      mem_req_ready = 1'b0;
      chk("R6", "mem_ret_ready", LW'(mem_ret_ready), LW'(1));
      mem_ret_valid = 1'b1; mem_ret_data = mem_line(addr);
      @(negedge clk);
      mem_ret_valid = 1'b0;
      chk("R6", "ret rsp_valid", LW'(rsp_valid), LW'(1));
      chk("R6", "ret rsp_hit", LW'(rsp_hit), LW'(0));
      chk("R6", "ret rsp_data", rsp_data, mem_line(addr));
    end
    begin
      logic [LW-1:0] held;
      held = rsp_data;
      @(negedge clk);
      chk("R2", "rsp held valid", LW'(rsp_valid), LW'(1));
      chk("R2", "rsp held data", rsp_data, held);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    chk("R2", "back to idle", LW'(lkp_ready), LW'(1));
  endtask

  task automatic test_reset;
    chk("R1", "reset lkp_ready", LW'(lkp_ready), LW'(1));
    chk("R1", "reset rsp_valid", LW'(rsp_valid), LW'(0));
    chk("R1", "reset mem_req_valid", LW'(mem_req_valid), LW'(0));
    lookup(27'h0000040, 1'b0, 27'h0, 1'b0, '0, "R1");
  endtask

  task automatic test_swap;
    // insert A on a miss, swap A for B, then free B on a hit with nothing displaced
    lookup(27'h0000100, 1'b1, 27'h00000A0, 1'b0, '0, "R7");
    lookup(27'h00000A0, 1'b1, 27'h00000B0, 1'b1, ev_line(27'h00000A0), "R3");
    lookup(27'h00000B0, 1'b0, 27'h0, 1'b1, ev_line(27'h00000B0), "R4");
    lookup(27'h00000A0, 1'b0, 27'h0, 1'b0, '0, "R4");
    lookup(27'h00000B0, 1'b0, 27'h0, 1'b0, '0, "R10");
  endtask

  task automatic test_no_insert;
    lookup(27'h0000200, 1'b0, 27'h00000C0, 1'b0, '0, "R7");
    lookup(27'h00000C0, 1'b0, 27'h0, 1'b0, '0, "R7");
  endtask

  task automatic test_full_addr;
    lookup(27'h0000300, 1'b1, 27'h0001234, 1'b0, '0, "R7");
    lookup(27'h4001234, 1'b0, 27'h0, 1'b0, '0, "R8");
    lookup(27'h0001235, 1'b0, 27'h0, 1'b0, '0, "R8");
    lookup(27'h0001234, 1'b0, 27'h0, 1'b1, ev_line(27'h0001234), "R8");
  endtask

  task automatic test_replace;
    for (int k = 0; k < 4; k++)
      lookup(27'h0010000 + 27'(k), 1'b1, 27'h0000E00 + 27'(k), 1'b0, '0, "R9");
    // hit E1, displacing F into its slot; order oldest->newest: E0 E2 E3 F
    lookup(27'h0000E01, 1'b1, 27'h0000F00, 1'b1, ev_line(27'h0000E01), "R9");
    // full: inserting G overwrites E0
    lookup(27'h0010010, 1'b1, 27'h0000A10, 1'b0, '0, "R9");
    lookup(27'h0000E00, 1'b0, 27'h0, 1'b0, '0, "R9");
    // free E2, then H must use the freed slot
    lookup(27'h0000E02, 1'b0, 27'h0, 1'b1, ev_line(27'h0000E02), "R10");
    lookup(27'h0010020, 1'b1, 27'h0000B20, 1'b0, '0, "R9");
    lookup(27'h0000E03, 1'b0, 27'h0, 1'b1, ev_line(27'h0000E03), "R9");
    lookup(27'h0000F00, 1'b0, 27'h0, 1'b1, ev_line(27'h0000F00), "R9");
    lookup(27'h0000A10, 1'b0, 27'h0, 1'b1, ev_line(27'h0000A10), "R9");
    lookup(27'h0000B20, 1'b0, 27'h0, 1'b1, ev_line(27'h0000B20), "R9");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    test_swap();
    test_no_insert();
    test_full_addr();
    test_replace();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule